// File: doc/BRIEF.md
# Display mode register file

This block is the software-visible configuration bank of a simple linear-framebuffer display controller. A bus master addresses it with a byte address; the lower part of the map is a bank of 16-bit registers where the register index is the byte address divided by two, and a small 32-bit window sitting at a configurable base holds the framebuffer byte-order setting. The scanout logic elsewhere in the chip reads the stored resolution, pixel depth, line width and origin values; this block only holds them and answers reads.

Two bank slots are reserved and answer with constants: an identification code that drivers probe first, and the video memory size in 64 KiB units. Bank slots past the end of storage answer with all ones so that probing software can see where the bank ends. The byte-order flag moves only when one of two exact 32-bit patterns is written, so stray writes cannot flip it.

Top module: `dispcfg_regfile`

## Requirements
- R1: An address below EXT_BASE (default 0x100) selects the bank; the register index is the byte address shifted right by one, so byte addresses 2k and 2k+1 reach the same register. Writes store wdata[15:0]; reads return the 16-bit value zero-extended to 32 bits. The wide input does not matter in the bank.
- R2: A read of index 0 returns ID_VALUE (default 0xB0C5) whatever has been written there.
- R3: A read of index 10 returns VMEM_BYTES / 65536 (default 16 MiB, so 0x0100); writes there change nothing.
- R4: Indices 1 to 9 are plain 16-bit storage that clears to zero on reset: 1 horizontal resolution, 2 vertical resolution, 3 pixel depth, 4 enable, 6 line width in pixels, 8 horizontal origin, 9 vertical origin; 5 and 7 are spare storage.
- R5: A bank index of 11 or above reads 0x0000FFFF and a write there changes no register.
- R6: The extension window spans 8 bytes from EXT_BASE: offset 0 reads 8, offset 4 reads the byte-order pattern, any other offset reads 0. Addresses at or above EXT_BASE+8 read 0 and ignore writes.
- R7: A wide write to extension offset 4 of 0xBEBEBEBE selects big-endian, of 0x1E1E1E1E selects little-endian, and of any other value leaves the flag as it was. After reset the flag is little-endian, so offset 4 reads 0x1E1E1E1E.
- R8: The extension window answers only 32-bit accesses (wide = 1): a narrow read there returns 0 and a narrow write is dropped.
- R9: rdata is registered: the value for a read issued with re high in one cycle appears after that clock edge, a read in the same cycle as a write returns the value from before the write, rdata holds while re is low, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | 32 | Write data |
| wide | input | 1 | 1 = 32-bit access, 0 = narrower access |
| we | input | 1 | Write enable |
| re | input | 1 | Read enable |
| rdata | output | 32 | Registered read data |

## Verification
The hardest case to reach from the ports is a stray write that must leave state alone: a non-pattern value to the byte-order register, a narrow write into the extension window, or a write past the end of the bank. The stimulus first moves the flag to big-endian with the exact pattern, then issues each kind of stray write and reads back, so an unchanged result is distinguishable from the reset value. The same-cycle read and write case is driven by raising re and we together on a stored register whose old and new values differ.

// File: rtl/dispcfg_pkg.sv
package dispcfg_pkg;
    localparam logic [31:0] BO_BIG    = 32'hBEBE_BEBE;
    localparam logic [31:0] BO_LITTLE = 32'h1E1E_1E1E;
    localparam int          EXT_SPAN  = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_MEM,
        SEL_REG,
        SEL_OOR,
        SEL_EXTSZ,
        SEL_EXTBO
    } sel_e;
endpackage

// File: rtl/dispcfg_decode.sv
module dispcfg_decode
    import dispcfg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 10,
    parameter int ID_IDX   = 0,
    parameter int MEM_IDX  = 10,
    parameter int EXT_BASE = 256,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output sel_e              sel,
    output logic [IDX_W-1:0]  reg_idx
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(EXT_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(EXT_SPAN);
    localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_IDX);
    localparam logic [ADDR_W-1:0] MEM_A  = ADDR_W'(MEM_IDX);
    localparam logic [ADDR_W-1:0] NUM_A  = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] BO_OFF = ADDR_W'(4);

    logic [ADDR_W-1:0] full_idx;
    logic [ADDR_W-1:0] ext_off;

    always_comb begin
        full_idx = addr >> 1;
        ext_off  = addr - BASE_A;
        reg_idx  = full_idx[IDX_W-1:0];
        sel      = SEL_NONE;
        if (addr < BASE_A) begin
            if (full_idx == ID_A)       sel = SEL_ID;
            else if (full_idx == MEM_A) sel = SEL_MEM;
            else if (full_idx < NUM_A)  sel = SEL_REG;
            else                        sel = SEL_OOR;
        end else if (ext_off < SPAN_A && wide) begin
            if (ext_off == '0)          sel = SEL_EXTSZ;
            else if (ext_off == BO_OFF) sel = SEL_EXTBO;
        end
    end
endmodule

// File: rtl/dispcfg_bank.sv
module dispcfg_bank #(
    parameter int NUM_REGS = 10,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      wval,
    output logic [15:0]      rval
);
    typedef struct packed {
        logic [NUM_REGS-1:0][15:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rval = '0;
        if (32'(idx) < NUM_REGS) begin
            rval = st_q.regs[idx];
            if (wr_en) st_d.regs[idx] = wval;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.regs));
    // R4
    bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(idx) < NUM_REGS) |=> st_q.regs[$past(idx)] == $past(wval));
endmodule

// File: rtl/dispcfg_ext.sv
module dispcfg_ext
    import dispcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bo_wr,
    input  logic [31:0] wval,
    output logic        big_q
);
    typedef struct packed {
        logic big;
    } ext_t;

    ext_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bo_wr) begin
            if (wval == BO_BIG)    st_d.big = 1'b1;
            if (wval == BO_LITTLE) st_d.big = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign big_q = st_q.big;

    // R7
    bo_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_wr && wval != BO_BIG && wval != BO_LITTLE) |=> $stable(big_q));
    // R7
    bo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_wr && wval == BO_BIG) |=> big_q);
    // R7
    bo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bo_wr && wval == BO_LITTLE) |=> !big_q);
endmodule

// File: rtl/dispcfg_regfile.sv
module dispcfg_regfile
    import dispcfg_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_REGS   = 10,
    parameter int          ID_IDX     = 0,
    parameter int          MEM_IDX    = 10,
    parameter int          EXT_BASE   = 256,
    parameter logic [15:0] ID_VALUE   = 16'hB0C5,
    parameter longint      VMEM_BYTES = 64'd16777216,
    localparam int         IDX_W      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wide,
    input  logic              we,
    input  logic              re,
    output logic [31:0]       rdata
);
    localparam logic [15:0] MEM_UNITS = 16'(VMEM_BYTES / 65536);

    typedef struct packed {
        logic [31:0] rd;
    } top_t;

    top_t             st_d, st_q;
    sel_e             sel;
    logic [IDX_W-1:0] reg_idx;
    logic [15:0]      bank_val;
    logic             big;

    dispcfg_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .ID_IDX(ID_IDX),
        .MEM_IDX(MEM_IDX), .EXT_BASE(EXT_BASE)
    ) u_dec (
        .addr(addr), .wide(wide), .sel(sel), .reg_idx(reg_idx)
    );

    dispcfg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(we && sel == SEL_REG),
        .idx(reg_idx), .wval(wdata[15:0]), .rval(bank_val)
    );

    dispcfg_ext u_ext (
        .clk(clk), .rst_n(rst_n),
        .bo_wr(we && sel == SEL_EXTBO),
        .wval(wdata), .big_q(big)
    );

    always_comb begin
        st_d = st_q;
        if (re) begin
            unique case (sel)
                SEL_ID:    st_d.rd = {16'h0, ID_VALUE};
                SEL_MEM:   st_d.rd = {16'h0, MEM_UNITS};
                SEL_REG:   st_d.rd = {16'h0, bank_val};
                SEL_OOR:   st_d.rd = 32'h0000_FFFF;
                SEL_EXTSZ: st_d.rd = 32'(EXT_SPAN);
                SEL_EXTBO: st_d.rd = big ? BO_BIG : BO_LITTLE;
                default:   st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rd;

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
    // R2
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sel == SEL_ID) |=> rdata == {16'h0, ID_VALUE});
    // R5
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sel == SEL_OOR) |=> rdata == 32'h0000_FFFF);
    // R8
    narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && !wide && addr >= ADDR_W'(EXT_BASE)) |=> rdata == '0);
endmodule

// File: tb/dispcfg_regfile_test.sv
module dispcfg_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wide = 1'b0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    bit          rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [11:0] EXT = 12'h100;
    localparam logic [31:0] BIG = 32'hBEBEBEBE;
    localparam logic [31:0] LIT = 32'h1E1E1E1E;

    dispcfg_regfile uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wide(wide), .we(we), .re(re), .rdata(rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) rd_seen <= re;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: one expected item per completed read
    always @(negedge clk) begin
        if (rst_n && rd_seen && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic w);
        addr = a; wdata = d; wide = w; we = 1'b1; re = 1'b0;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic w, input logic [31:0] exp, input string tag);
        addr = a; wide = w; re = 1'b1; we = 1'b0;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic rdwr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] exp, input string tag);
        addr = a; wdata = d; wide = 1'b0; re = 1'b1; we = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        re = 1'b0; we = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        rd(12'h002, 1'b0, 32'h0, "R4 xres reset");
        rd(EXT + 12'h4, 1'b1, LIT, "R7 reset little-endian");
        rd(12'h000, 1'b0, 32'h0000B0C5, "R2 id read");
        rd(12'h014, 1'b0, 32'h00000100, "R3 memory size");

        wr(12'h002, 32'h1234_0280, 1'b0);
        wr(12'h005, 32'h0000_01E0, 1'b1);
        wr(12'h010, 32'h0000_0020, 1'b0);
        wr(12'h012, 32'h0000_0011, 1'b0);
        rd(12'h002, 1'b0, 32'h0000_0280, "R1 low half stored");
        rd(12'h004, 1'b0, 32'h0000_01E0, "R1 odd byte same register");
        rd(12'h011, 1'b1, 32'h0000_0020, "R4 x origin");
        rd(12'h012, 1'b0, 32'h0000_0011, "R4 y origin");

        wr(12'h000, 32'h0000_1234, 1'b0);
        rd(12'h001, 1'b0, 32'h0000B0C5, "R2 id after write");
        wr(12'h014, 32'h0000_5555, 1'b0);
        rd(12'h014, 1'b0, 32'h00000100, "R3 size after write");

        rd(12'h016, 1'b0, 32'h0000FFFF, "R5 index 11 reads ones");
        rd(12'h0FE, 1'b0, 32'h0000FFFF, "R5 last bank index");
        wr(12'h016, 32'h0000_0000, 1'b0);
        wr(12'h0FE, 32'h0000_0000, 1'b0);
        rd(12'h016, 1'b0, 32'h0000FFFF, "R5 still ones after write");
        rd(12'h002, 1'b0, 32'h0000_0280, "R5 stored xres untouched");

        rd(EXT, 1'b1, 32'h8, "R6 window size");
        rd(EXT + 12'h2, 1'b1, 32'h0, "R6 other offset zero");
        rd(EXT + 12'h8, 1'b1, 32'h0, "R6 past window zero");

        wr(EXT + 12'h4, BIG, 1'b1);
        rd(EXT + 12'h4, 1'b1, BIG, "R7 big pattern sets");
        wr(EXT + 12'h4, 32'h1E1E1E1F, 1'b1);
        rd(EXT + 12'h4, 1'b1, BIG, "R7 other value keeps big");
        wr(EXT + 12'h4, LIT, 1'b0);
        rd(EXT + 12'h4, 1'b1, BIG, "R8 narrow write dropped");
        rd(EXT + 12'h4, 1'b0, 32'h0, "R8 narrow read zero");
        rd(EXT, 1'b0, 32'h0, "R8 narrow size read zero");
        wr(EXT + 12'h4, LIT, 1'b1);
        rd(EXT + 12'h4, 1'b1, LIT, "R7 little pattern clears");
        wr(EXT + 12'h4, 32'h0, 1'b1);
        rd(EXT + 12'h4, 1'b1, LIT, "R7 zero keeps little");

        rdwr(12'h006, 32'h0000_0020, 32'h0, "R9 same-cycle read sees old");
        rd(12'h006, 1'b0, 32'h0000_0020, "R9 new value after write");

        rd(12'h004, 1'b0, 32'h0000_01E0, "R9 read before hold");
        wr(12'h004, 32'h0000_0001, 1'b0);
        @(negedge clk);
        check("R9 rdata holds with re low", rdata, 32'h0000_01E0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule